// File: doc/BRIEF.md
# Packed Byte Saturating Array Adder

This engine adds two arrays of unsigned bytes into a third array. Each 32-bit memory word holds four byte elements, and any byte sum above 255 is clamped to 255. A command gives the element count and three word-aligned byte base addresses. The engine then walks the arrays one word at a time.

For each word it reads the first operand and then the second through one synchronous read port. It makes a single 32-bit addition that covers all four lanes and tests each lane boundary for a carry. If no enabled lane overflowed, the plain sum is written in the same cycle. If any enabled lane overflowed, the engine spends one more cycle. In that cycle it rebuilds every lane from the stored operands with independent 9-bit adds, clamps them, and writes the result. Overflow is expected to be rare, so the common word costs three cycles.

Two 32-bit counters report the busy cycles and the correction cycles of the last command. A one-cycle done pulse marks the end of each command.

Top module: `sat_add_engine`

## Requirements
- R1: Every written byte lane equals min(a_lane + b_lane, 255), where lane k is bits 8k+7..8k of a word and a_lane, b_lane are the two operand bytes of that lane.
- R2: A word with no overflow in any enabled lane takes three busy cycles: read A, read B, then add with the write in that same cycle. No correction cycle is spent on it.
- R3: A word with an overflow in at least one enabled lane takes exactly one extra cycle, the correction cycle, before its write. Each lane is rebuilt on its own, so a carry out of a lower lane never changes a higher lane.
- R4: For word i, the engine reads A at src_a_i+4i, then reads B at src_b_i+4i, and writes at dst_i+4i. Read data is taken one cycle after the read enable.
- R5: When len_i mod 4 = r is not 0, the last word is written with byte enable bits [r-1:0] set and the others clear. An overflow in a disabled lane does not cause a correction cycle. All other writes use byte enable 4'b1111.
- R6: cycles_o counts busy cycles, so it equals 3*ceil(len_i/4) plus the number of correction cycles. It clears when a start is accepted.
- R7: fixes_o counts the correction cycles of the command and clears when a start is accepted.
- R8: done_o is high for exactly one cycle. That cycle is the one after the final write.
- R9: A start pulse is ignored while a command is in progress: no memory access, operands or counters change because of it.
- R10: A start with len_i = 0 makes no memory access, leaves both counters at 0, and pulses done_o in the cycle after the start.
- R11: While reset is held, done_o, mem_re_o and mem_we_o are low and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| len_i | input | 16 | Element count in bytes |
| src_a_i | input | 32 | Byte base address of array A, word aligned |
| src_b_i | input | 32 | Byte base address of array B, word aligned |
| dst_i | input | 32 | Byte base address of result array, word aligned |
| mem_re_o | output | 1 | Read enable |
| mem_raddr_o | output | 32 | Read byte address |
| mem_rdata_i | input | 32 | Read data, valid the cycle after mem_re_o |
| mem_we_o | output | 1 | Write enable |
| mem_waddr_o | output | 32 | Write byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Write byte enables, bit k for lane k |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | 32 | Busy cycles of the last command |
| fixes_o | output | 32 | Correction cycles of the last command |

## Verification
The vector table includes words where a lower lane's carry would ripple into a lane whose own sum is exactly 255. A design that trusted the wide sum would write 0x00 in that lane instead of 0xFF. It also includes words that fill every lane to 0xFF without overflow. A design that signals overflow too eagerly spends extra cycles on them, and the cycle and correction counts show it.

Partial last words are run with overflowing bytes placed in the disabled lanes. A wrong byte enable overwrites the preset destination bytes, and a missing lane mask adds a correction cycle. Other tests cover an empty command, a start pulse issued in mid-run, and the placement of the done pulse. These catch an engine that touches memory when it should not, restarts when it should ignore a start, or signals done early.

// File: rtl/sat_add_pkg.sv
package sat_add_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_A, ST_RD_B, ST_ADD, ST_FIX, ST_FIN
  } eng_state_e;
  localparam int unsigned LANES = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;
endpackage

// File: rtl/lane_carry_detect.sv
module lane_carry_detect
  import sat_add_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [LANES-1:0]  lane_en_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              ovf_o
);
  logic [WORD_W:0]    wide;
  logic [WORD_W:0]    carry_in;
  logic [LANES-1:0]   lane_cout;

  assign wide     = {1'b0, a_i} + {1'b0, b_i};
  // carry into each bit position of the wide add
  assign carry_in = wide ^ {1'b0, a_i ^ b_i};
  assign sum_o    = wide[WORD_W-1:0];

  for (genvar l = 0; l < LANES; l++) begin : g_cout
    assign lane_cout[l] = carry_in[(l+1)*LANE_W];
  end

  // lowest boundary carry always has zero carry-in, so any carry means a true lane overflow
  assign ovf_o = |(lane_cout & lane_en_i);
endmodule

// File: rtl/lane_fix.sv
module lane_fix
  import sat_add_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] sat_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W:0] s;
    assign s = {1'b0, a_i[l*LANE_W +: LANE_W]} + {1'b0, b_i[l*LANE_W +: LANE_W]};
    assign sat_o[l*LANE_W +: LANE_W] = s[LANE_W] ? {LANE_W{1'b1}} : s[LANE_W-1:0];
  end
endmodule

// File: rtl/word_addr_gen.sv
module word_addr_gen
  import sat_add_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] base_a_i,
  input  logic [ADDR_W-1:0] base_b_i,
  input  logic [ADDR_W-1:0] base_d_i,
  output logic [ADDR_W-1:0] addr_a_o,
  output logic [ADDR_W-1:0] addr_b_o,
  output logic [ADDR_W-1:0] addr_d_o,
  output logic              last_o,
  output logic [LANES-1:0]  lane_en_o
);
  localparam int unsigned OFF_W = LEN_W - 1;

  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] ba_q, bb_q, bd_q;
  logic [OFF_W-1:0]  off_q;
  logic [LEN_W-1:0]  words;
  logic [ADDR_W-1:0] byte_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0; ba_q <= '0; bb_q <= '0; bd_q <= '0; off_q <= '0;
    end else if (load_i) begin
      len_q <= len_i; ba_q <= base_a_i; bb_q <= base_b_i; bd_q <= base_d_i;
      off_q <= '0;
    end else if (step_i) begin
      off_q <= off_q + 1'b1;
    end
  end

  assign words    = LEN_W'(({1'b0, len_q} + (LEN_W+1)'(3)) >> 2);
  assign byte_off = ADDR_W'({off_q, 2'b00});
  assign addr_a_o = ba_q + byte_off;
  assign addr_b_o = bb_q + byte_off;
  assign addr_d_o = bd_q + byte_off;
  assign last_o   = (LEN_W'(off_q) == words - 1'b1);

  always_comb begin
    lane_en_o = '1;
    if (last_o) begin
      unique case (len_q[1:0])
        2'd1:    lane_en_o = 4'b0001;
        2'd2:    lane_en_o = 4'b0011;
        2'd3:    lane_en_o = 4'b0111;
        default: lane_en_o = 4'b1111;
      endcase
    end
  end

  p_len_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i) |=> $stable(len_q));
endmodule

// File: rtl/sat_add_engine.sv
module sat_add_engine
  import sat_add_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] src_a_i,
  input  logic [ADDR_W-1:0] src_b_i,
  input  logic [ADDR_W-1:0] dst_i,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  cycles_o,
  output logic [CNT_W-1:0]  fixes_o
);
  eng_state_e state_q, state_d;
  logic [WORD_W-1:0] a_q, b_q, wide_sum, fixed;
  logic [ADDR_W-1:0] addr_a, addr_b, addr_d;
  logic [LANES-1:0]  lane_en;
  logic last, ovf, load, step, busy;
  logic [CNT_W-1:0] cyc_q, fix_q;

  assign load = (state_q == ST_IDLE) && start_i;
  assign busy = (state_q == ST_RD_A) || (state_q == ST_RD_B) ||
                (state_q == ST_ADD) || (state_q == ST_FIX);

  word_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .len_i,
    .base_a_i(src_a_i), .base_b_i(src_b_i), .base_d_i(dst_i),
    .addr_a_o(addr_a), .addr_b_o(addr_b), .addr_d_o(addr_d),
    .last_o(last), .lane_en_o(lane_en)
  );

  lane_carry_detect u_det (
    .a_i(a_q), .b_i(mem_rdata_i), .lane_en_i(lane_en),
    .sum_o(wide_sum), .ovf_o(ovf)
  );

  lane_fix u_fix (.a_i(a_q), .b_i(b_q), .sat_o(fixed));

  always_comb begin
    state_d     = state_q;
    mem_re_o    = 1'b0;
    mem_raddr_o = addr_a;
    mem_we_o    = 1'b0;
    mem_wdata_o = wide_sum;
    step        = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = (len_i == '0) ? ST_FIN : ST_RD_A;
      ST_RD_A: begin mem_re_o = 1'b1; state_d = ST_RD_B; end
      ST_RD_B: begin mem_re_o = 1'b1; mem_raddr_o = addr_b; state_d = ST_ADD; end
      ST_ADD: begin
        if (ovf) state_d = ST_FIX;
        else begin
          mem_we_o = 1'b1;
          step     = !last;
          state_d  = last ? ST_FIN : ST_RD_A;
        end
      end
      ST_FIX: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = fixed;
        step        = !last;
        state_d     = last ? ST_FIN : ST_RD_A;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign mem_waddr_o = addr_d;
  assign mem_be_o    = lane_en;
  assign done_o      = (state_q == ST_FIN);
  assign cycles_o    = cyc_q;
  assign fixes_o     = fix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      a_q <= '0; b_q <= '0; cyc_q <= '0; fix_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RD_B) a_q <= mem_rdata_i;
      if (state_q == ST_ADD)  b_q <= mem_rdata_i;
      if (load) begin
        cyc_q <= '0;
        fix_q <= '0;
      end else begin
        if (busy) cyc_q <= cyc_q + 1'b1;
        if (state_q == ST_FIX) fix_q <= fix_q + 1'b1;
      end
    end
  end

  p_fix_after_add_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIX) |-> ($past(state_q) == ST_ADD) && mem_we_o);
  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADD && !ovf) |-> mem_we_o && mem_wdata_o == wide_sum);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && last) |=> done_o);
  p_be_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_be_o != '0);
  p_rw_exclusive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  p_fix_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIX) |=> fix_q == $past(fix_q) + 1'b1);
endmodule

// File: tb/tb_sat_add_engine.sv
module tb_sat_add_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] len = '0;
  logic [31:0] src_a = '0, src_b = '0, dst = '0;
  logic re, we, done;
  logic [31:0] raddr, waddr, wdata, cycles, fixes;
  logic [31:0] rdata = '0;
  logic [3:0] be;
  logic [31:0] mem [256];
  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_we_cyc = -1, done_cyc = -1, any_we = 0, any_re = 0;

  always #5 clk = ~clk;

  sat_add_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len),
    .src_a_i(src_a), .src_b_i(src_b), .dst_i(dst),
    .mem_re_o(re), .mem_raddr_o(raddr), .mem_rdata_i(rdata),
    .mem_we_o(we), .mem_waddr_o(waddr), .mem_wdata_o(wdata), .mem_be_o(be),
    .done_o(done), .cycles_o(cycles), .fixes_o(fixes)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (re) rdata <= mem[raddr[9:2]];
    if (we) for (int l = 0; l < 4; l++) if (be[l]) mem[waddr[9:2]][8*l +: 8] <= wdata[8*l +: 8];
  end

  always @(negedge clk) begin
    if (we) begin last_we_cyc = cyc; any_we++; end
    if (re) any_re++;
    if (done) done_cyc = cyc;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic go(input logic [15:0] l, input logic [31:0] a, input logic [31:0] b,
                    input logic [31:0] d);
    @(negedge clk);
    start = 1'b1; len = l; src_a = a; src_b = b; dst = d;
    any_we = 0; any_re = 0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    if (!done) begin n_chk++; n_fail++; $display("FAIL R8 actual=timeout expected=done"); end
    @(negedge clk);
    check("R8 done one cycle", {31'b0, done}, 32'd0);
  endtask

  localparam logic [31:0] TA [8] = '{32'h01020304, 32'hFA000000, 32'h00007FFF, 32'h80808080,
                                     32'h00000000, 32'h7F00FF01, 32'h12345678, 32'h01010101};
  localparam logic [31:0] TB [8] = '{32'h10203040, 32'h14000000, 32'h00008001, 32'h80808080,
                                     32'hFFFFFFFF, 32'h01FF00FE, 32'hEDCBA988, 32'h01010101};
  localparam logic [31:0] TE [8] = '{32'h11223344, 32'hFF000000, 32'h0000FFFF, 32'hFFFFFFFF,
                                     32'hFFFFFFFF, 32'h80FFFFFF, 32'hFFFFFFFF, 32'h02020202};

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hAAAAAAAA;
    for (int i = 0; i < 8; i++) begin mem[i] = TA[i]; mem[64+i] = TB[i]; end
    mem[224] = 32'h5A5A5A5A;
    repeat (3) @(negedge clk);
    check("R11 done", {31'b0, done}, 0);
    check("R11 re/we", {30'b0, re, we}, 0);
    check("R11 cycles", cycles, 0);
    check("R11 fixes", fixes, 0);
    rst_n = 1'b1;

    // table run, with an ignored start in the middle
    go(16'd32, 32'h000, 32'h100, 32'h200);
    repeat (5) @(negedge clk);
    start = 1'b1; len = 16'd4; src_a = 32'h300; src_b = 32'h340; dst = 32'h380;
    @(negedge clk); start = 1'b0;
    wait_done();
    for (int i = 0; i < 8; i++) check($sformatf("R1 R3 word %0d", i), mem[128+i], TE[i]);
    check("R6 cycles", cycles, 32'd28);
    check("R7 fixes", fixes, 32'd4);
    check("R8 done after final write", done_cyc, last_we_cyc + 1);
    check("R9 ignored start dst", mem[224], 32'h5A5A5A5A);
    check("R4 dst neighbour", mem[136], 32'hAAAAAAAA);

    // single word, no overflow: counters cleared by new start
    mem[192] = 32'h01010101; mem[208] = 32'h02020202;
    go(16'd4, 32'h300, 32'h340, 32'h3C0);
    wait_done();
    check("R2 single word cycles", cycles, 32'd3);
    check("R7 single word fixes", fixes, 32'd0);
    check("R4 single word result", mem[240], 32'h03030303);

    // partial word, overflow only in disabled lanes
    mem[192] = 32'h00000001; mem[193] = 32'hFFFF0102;
    mem[208] = 32'h00000002; mem[209] = 32'hFFFF0304;
    mem[224] = 32'hAAAAAAAA; mem[225] = 32'hAAAAAAAA;
    go(16'd6, 32'h300, 32'h340, 32'h380);
    wait_done();
    check("R5 partial lanes", mem[225], 32'hAAAA0406);
    check("R5 masked overflow fixes", fixes, 32'd0);
    check("R6 partial cycles", cycles, 32'd6);

    // partial word, overflow in enabled lane
    mem[193] = 32'h000000F0; mem[209] = 32'h00000020; mem[225] = 32'hAAAAAAAA;
    go(16'd5, 32'h300, 32'h340, 32'h380);
    wait_done();
    check("R5 R3 partial fix", mem[225], 32'hAAAAAAFF);
    check("R3 one correction", fixes, 32'd1);
    check("R6 cycles with fix", cycles, 32'd7);

    // empty command
    go(16'd0, 32'h300, 32'h340, 32'h380);
    check("R10 done next cycle", {31'b0, done}, 32'd1);
    check("R10 no memory access", any_we + any_re, 0);
    check("R10 cycles", cycles, 0);
    check("R10 fixes", fixes, 0);
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule